// File: doc/BRIEF.md
# Duplicated AES Byte Substitution with Mismatch Detection

This block applies the AES byte substitution to a full 128-bit state in one step. It covers the forward direction used for encryption and the inverse direction used for decryption. Two substitution layers, built separately, evaluate the same input at the same time. Each layer works out every S-box entry arithmetically: a multiplicative inverse in GF(2^8) together with an affine map over GF(2). No lookup table is used.

A comparator checks the two results byte by byte. Any difference sets a fault flag, which stays set until a clear input is asserted. The result from the primary layer, the output strobe and the fault flag are registered together, so each accepted input gives its result one cycle later. The surrounding round logic uses the fault flag to decide how to react. That reaction is outside this block.

Top module: `sbox_dup_guard`

## Requirements
- R1: With mode_i = 0, each output byte state_o[8j+7:8j] is the forward AES S-box of input byte state_i[8j+7:8j], for j = 0 to 15, with every byte handled independently (for example 0x00→0x63, 0x01→0x7C, 0x53→0xED, 0xFF→0x16).
- R2: With mode_i = 1, each output byte is the inverse AES S-box of the matching input byte (for example 0x63→0x00, 0x7C→0x01, 0xED→0x53, 0x16→0xFF, 0x00→0x52).
- R3: For all 256 byte values, a forward pass followed by an inverse pass on the result gives back the original byte.
- R4: A state accepted with valid_i high appears on state_o one clock later, with valid_o high in that same cycle. valid_o is low one cycle after valid_i is low, and state_o holds its value on those cycles.
- R5: When the two substitution layers disagree in any byte during a cycle with valid_i high, fault_o is high from the next clock on.
- R6: Once fault_o is set, it stays high until clr_i is sampled high with no new mismatch. A clear clears it on the next clock.
- R7: If clr_i and a valid mismatch happen in the same cycle, fault_o stays set.
- R8: After reset, state_o is zero and valid_o and fault_o are low. Layers that agree, for any input, never set fault_o.
- R9: A mismatch between the layers during a cycle with valid_i low does not set fault_o and does not change state_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 0 = forward substitution, 1 = inverse substitution |
| valid_i | input | 1 | Input state is valid this cycle |
| state_i | input | 128 | Input state, byte j at bits 8j+7:8j |
| clr_i | input | 1 | Clears the sticky fault flag |
| state_o | output | 128 | Substituted state from the primary layer |
| valid_o | output | 1 | state_o holds a fresh result |
| fault_o | output | 1 | Sticky mismatch flag |

## Verification
The hard case is a disagreement between the two layers. Both layers compute the same function, so no input at the ports can ever make them differ. The bench therefore forces the shadow layer's result inside the block to a wrong value for a single cycle, then releases it. It does this with valid_i high, with valid_i low, and at the same time as a clear, and it observes only fault_o and state_o. An exhaustive forward-then-inverse sweep over all 256 byte values confirms that fault-free operation never raises the flag.

// File: rtl/sbox_dup_pkg.sv
package sbox_dup_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [7:0] RED_POLY = 8'h1B;  // x^8+x^4+x^3+x+1, high bit implied
  localparam logic [7:0] FWD_C    = 8'h63;
  localparam logic [7:0] INV_C    = 8'h05;

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? RED_POLY : 8'h00);
    end
    return p;
  endfunction

  // a^254 = a^-1, and 0 maps to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] base;
    logic [7:0] e;
    r    = 8'h01;
    base = a;
    e    = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gf_mul(r, base);
      base = gf_mul(base, base);
    end
    return r;
  endfunction

  function automatic logic [7:0] aff_fwd(input logic [7:0] b);
    logic [7:0] o;
    for (int i = 0; i < 8; i++)
      o[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8] ^ FWD_C[i];
    return o;
  endfunction

  function automatic logic [7:0] aff_inv(input logic [7:0] b);
    logic [7:0] o;
    for (int i = 0; i < 8; i++)
      o[i] = b[(i+2)%8] ^ b[(i+5)%8] ^ b[(i+7)%8] ^ INV_C[i];
    return o;
  endfunction
endpackage

// File: rtl/sbox_unit.sv
module sbox_unit
  import sbox_dup_pkg::*;
(
  input  logic       inv_i,
  input  logic [7:0] byte_i,
  output logic [7:0] byte_o
);
  logic [7:0] pre_inv;
  logic [7:0] post_inv;

  // one shared field inverter; the affine step sits before it or after it, by mode
  always_comb begin
    pre_inv  = inv_i ? aff_inv(byte_i) : byte_i;
    post_inv = gf_inv(pre_inv);
    byte_o   = inv_i ? post_inv : aff_fwd(post_inv);
  end
endmodule

// File: rtl/sub_layer.sv
module sub_layer #(
  parameter int unsigned N_BYTES = 16,
  localparam int unsigned W = N_BYTES * 8
) (
  input  logic         inv_i,
  input  logic [W-1:0] state_i,
  output logic [W-1:0] state_o
);
  for (genvar j = 0; j < N_BYTES; j++) begin : g_box
    sbox_unit u_box (
      .inv_i  (inv_i),
      .byte_i (state_i[8*j +: 8]),
      .byte_o (state_o[8*j +: 8])
    );
  end
endmodule

// File: rtl/sub_cmp.sv
module sub_cmp #(
  parameter int unsigned N_BYTES = 16,
  localparam int unsigned W = N_BYTES * 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         diff_o
);
  logic [N_BYTES-1:0] byte_ne;
  for (genvar j = 0; j < N_BYTES; j++) begin : g_ne
    assign byte_ne[j] = a_i[8*j +: 8] != b_i[8*j +: 8];
  end
  assign diff_o = |byte_ne;
endmodule

// File: rtl/sbox_dup_guard.sv
module sbox_dup_guard #(
  parameter int unsigned N_BYTES = 16,
  localparam int unsigned W = N_BYTES * 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mode_i,
  input  logic         valid_i,
  input  logic [W-1:0] state_i,
  input  logic         clr_i,
  output logic [W-1:0] state_o,
  output logic         valid_o,
  output logic         fault_o
);
  logic [W-1:0] primary_sub;
  logic [W-1:0] shadow_sub;
  logic         layer_diff;

  sub_layer #(.N_BYTES(N_BYTES)) u_primary (
    .inv_i(mode_i), .state_i(state_i), .state_o(primary_sub)
  );

  sub_layer #(.N_BYTES(N_BYTES)) u_shadow (
    .inv_i(mode_i), .state_i(state_i), .state_o(shadow_sub)
  );

  sub_cmp #(.N_BYTES(N_BYTES)) u_cmp (
    .a_i(primary_sub), .b_i(shadow_sub), .diff_o(layer_diff)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= '0;
      valid_o <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) state_o <= primary_sub;
      // a new mismatch outranks a clear in the same cycle
      fault_o <= (fault_o & ~clr_i) | (valid_i & layer_diff);
    end
  end
endmodule

// File: rtl/sbox_dup_chk.sv
module sbox_dup_chk #(
  parameter int unsigned W = 128
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic         clr_i,
  input logic [W-1:0] primary_sub,
  input logic [W-1:0] shadow_sub,
  input logic [W-1:0] state_o,
  input logic         valid_o,
  input logic         fault_o
);
  // R4
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R4
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R9
  hold_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(state_o));
  // R5
  mismatch_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (primary_sub != shadow_sub)) |=> fault_o);
  // R6
  sticky_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !clr_i) |=> fault_o);
  // R9
  fault_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> $past(valid_i && (primary_sub != shadow_sub)));
endmodule

bind sbox_dup_guard sbox_dup_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .clr_i       (clr_i),
  .primary_sub (primary_sub),
  .shadow_sub  (shadow_sub),
  .state_o     (state_o),
  .valid_o     (valid_o),
  .fault_o     (fault_o)
);

// File: tb/sim_sbox_dup_guard.sv
`timescale 1ns/1ps
module sim_sbox_dup_guard;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         mode_i = 1'b0;
  logic         valid_i = 1'b0;
  logic [127:0] state_i = '0;
  logic         clr_i = 1'b0;
  logic [127:0] state_o;
  logic         valid_o;
  logic         fault_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  sbox_dup_guard u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive for one cycle, result registered at the posedge, sampled at the next negedge
  task automatic apply(input logic m, input logic [127:0] s);
    @(negedge clk_i);
    mode_i = m; state_i = s; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  function automatic logic [127:0] fill(input logic [7:0] b);
    logic [127:0] r;
    for (int j = 0; j < 16; j++) r[8*j +: 8] = b;
    return r;
  endfunction

  task automatic t_reset();
    chk(state_o == '0, "R8 reset state_o", state_o, '0);
    chk(valid_o == 1'b0, "R8 reset valid_o", valid_o, 0);
    chk(fault_o == 1'b0, "R8 reset fault_o", fault_o, 0);
  endtask

  task automatic t_forward();
    logic [127:0] in_v, exp_v;
    in_v  = {8'h53, 8'hFF, 8'h01, 8'h00, 8'h53, 8'h01, 8'hFF, 8'h00,
             8'h00, 8'h00, 8'h01, 8'h53, 8'hFF, 8'hFF, 8'h53, 8'h01};
    exp_v = {8'hED, 8'h16, 8'h7C, 8'h63, 8'hED, 8'h7C, 8'h16, 8'h63,
             8'h63, 8'h63, 8'h7C, 8'hED, 8'h16, 8'h16, 8'hED, 8'h7C};
    apply(1'b0, in_v);
    chk(state_o == exp_v, "R1 forward mixed", state_o, exp_v);
    chk(valid_o == 1'b1, "R4 valid_o after accept", valid_o, 1);
    apply(1'b0, fill(8'h00));
    chk(state_o == fill(8'h63), "R1 forward zero", state_o, fill(8'h63));
  endtask

  task automatic t_inverse();
    logic [127:0] in_v, exp_v;
    in_v  = {8'h63, 8'h7C, 8'hED, 8'h16, 8'h00, 8'h63, 8'h16, 8'hED,
             8'h7C, 8'h00, 8'h63, 8'h63, 8'hED, 8'h16, 8'h7C, 8'h00};
    exp_v = {8'h00, 8'h01, 8'h53, 8'hFF, 8'h52, 8'h00, 8'hFF, 8'h53,
             8'h01, 8'h52, 8'h00, 8'h00, 8'h53, 8'hFF, 8'h01, 8'h52};
    apply(1'b1, in_v);
    chk(state_o == exp_v, "R2 inverse mixed", state_o, exp_v);
  endtask

  task automatic t_roundtrip();
    bit rt_ok = 1'b1;
    bit nf_ok = 1'b1;
    logic [127:0] orig, mid;
    for (int blk = 0; blk < 16; blk++) begin
      for (int j = 0; j < 16; j++) orig[8*j +: 8] = 8'(blk*16 + j);
      apply(1'b0, orig);
      mid = state_o;
      if (fault_o) nf_ok = 1'b0;
      apply(1'b1, mid);
      if (state_o != orig) begin
        rt_ok = 1'b0;
        chk(1'b0, "R3 roundtrip block", state_o, orig);
      end
      if (fault_o) nf_ok = 1'b0;
    end
    chk(rt_ok, "R3 roundtrip all 256", 0, 0);
    chk(nf_ok, "R8 no fault when layers agree", fault_o, 0);
  endtask

  task automatic t_idle_hold();
    logic [127:0] held;
    held = state_o;
    @(negedge clk_i);
    state_i = fill(8'hAA); mode_i = 1'b0;
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R4 valid_o low when idle", valid_o, 0);
    chk(state_o == held, "R4 state_o holds when idle", state_o, held);
  endtask

  task automatic t_ignored_mismatch();
    logic [127:0] held;
    held = state_o;
    @(negedge clk_i);
    state_i = fill(8'h53); valid_i = 1'b0;
    force u0.shadow_sub = 128'h0;
    @(negedge clk_i);
    release u0.shadow_sub;
    chk(fault_o == 1'b0, "R9 idle mismatch ignored fault", fault_o, 0);
    chk(state_o == held, "R9 idle mismatch ignored state", state_o, held);
  endtask

  task automatic t_detect_sticky();
    @(negedge clk_i);
    mode_i = 1'b0; state_i = fill(8'h53); valid_i = 1'b1;
    force u0.shadow_sub = fill(8'hEC);
    @(negedge clk_i);
    release u0.shadow_sub;
    valid_i = 1'b0;
    chk(fault_o == 1'b1, "R5 mismatch detected", fault_o, 1);
    chk(state_o == fill(8'hED), "R5 primary result kept", state_o, fill(8'hED));
    repeat (3) @(negedge clk_i);
    chk(fault_o == 1'b1, "R6 fault sticky", fault_o, 1);
    clr_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0;
    chk(fault_o == 1'b0, "R6 clear", fault_o, 0);
  endtask

  task automatic t_clear_collision();
    apply(1'b0, fill(8'h01));
    @(negedge clk_i);
    mode_i = 1'b0; state_i = fill(8'h01); valid_i = 1'b1; clr_i = 1'b1;
    force u0.shadow_sub[7:0] = 8'h00;
    @(negedge clk_i);
    release u0.shadow_sub;
    valid_i = 1'b0; clr_i = 1'b0;
    chk(fault_o == 1'b1, "R7 mismatch beats clear", fault_o, 1);
    clr_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0;
    chk(fault_o == 1'b0, "R6 clear after collision", fault_o, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_forward();
    t_inverse();
    t_idle_hold();
    t_roundtrip();
    t_ignored_mismatch();
    t_detect_sticky();
    t_clear_collision();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule